// File: doc/BRIEF.md
# Range-Based Memory Protection Checker

This block judges every memory access of a processor against programmable address windows. It keeps several complete protection register sets. A 2-bit selector, normally taken from a field of the processor status word, names the one set that is active. Each set has two separate parts. The data part has four windows and checks loads and stores. The code part has two windows and checks instruction fetches. Each window is a pair of bound registers. Each part also has one mode register that grants rights window by window.

An access is offered with a valid strobe, an address, an access kind and the set selector. One clock later the block raises either a grant flag or a one-cycle trap pulse. The trap pulse carries the kind of the rejected access, so the trap logic can tell a fetch violation from a data violation. Software programs the bounds and the mode words through a single-cycle write port.

Top module: `range_mpu`

## Requirements
- R1: After reset every bound and every mode word is zero, so each access of any kind in any set is denied with a trap.
- R2: An address lies in a window when lower <= address < upper, with unsigned comparison. The upper bound itself lies outside, and a window whose lower bound is not below its upper bound contains no address.
- R3: A read (acc_kind 2'b00) is granted only if a data window of the active set contains the address and has its read bit set. The read bit of data window i is bit 2*i of the data mode word.
- R4: A write (acc_kind 2'b01) is granted only if a data window of the active set contains the address and has its write bit set. The write bit of data window i is bit 2*i+1 of the data mode word.
- R5: A fetch (acc_kind 2'b10) is granted only if a code window of the active set contains the address and has its execute bit set. The execute bit of code window i is bit i of the code mode word.
- R6: Fetches ignore the data windows, and reads and writes ignore the code windows.
- R7: Only the set named by set_sel is consulted. Windows programmed in any other set have no effect on the verdict.
- R8: When windows overlap, one containing window that grants the access is enough. A containing window that lacks the right does not veto it.
- R9: The verdict for an access with acc_valid high in cycle t appears in cycle t+1. In that cycle exactly one of acc_grant and acc_trap is high, each for one cycle. Both stay low after a cycle with acc_valid low.
- R10: When acc_trap is high, trap_kind equals the acc_kind of the rejected access. Otherwise trap_kind is 2'b00.
- R11: The write port address is {set[6:5], part[4] (0 data, 1 code), mode[3], index[2:1], upper[0]}. A mode write takes cfg_wdata[7:0] for data and cfg_wdata[1:0] for code. A write to code index 2 or 3 is ignored. A write takes effect for accesses offered in the next cycle.
- R12: The reserved access kind 2'b11 is always denied with a trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register write address (set, part, mode, index, upper) |
| cfg_wdata | input | 32 | Register write data |
| set_sel | input | 2 | Active protection set |
| acc_valid | input | 1 | Access offered this cycle |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved |
| acc_addr | input | 32 | Access address |
| acc_grant | output | 1 | Access allowed (one cycle after request) |
| acc_trap | output | 1 | One-cycle trap pulse for a denied access |
| trap_kind | output | 2 | Kind of the denied access while acc_trap is high |

## Verification
The assertions assume that acc_valid, acc_kind and set_sel are known values at every clock edge after reset. They also take every set_sel value as legal, which holds because the default set count fills the 2-bit selector. The bench drives inputs only on the falling clock edge, so no input is ever unknown or changing at a rising edge. It picks set_sel in the range 0 to 3 and includes the reserved kind on purpose. Random bounds and addresses are kept inside a small window so that hits, misses, empty windows and overlaps all occur often.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    // Geometry
    localparam int NUM_SETS   = 4;
    localparam int DATA_WINS  = 4;
    localparam int CODE_WINS  = 2;
    localparam int DATA_PERMS = 2;   // read, write
    localparam int CODE_PERMS = 1;   // execute
    localparam int ADDR_W     = 32;

    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int IDX_W  = $clog2((DATA_WINS > CODE_WINS) ? DATA_WINS : CODE_WINS);
    // Write-port address field positions
    localparam int POS_UPPER = 0;
    localparam int POS_IDX   = 1;
    localparam int POS_MODE  = POS_IDX + IDX_W;
    localparam int POS_PART  = POS_MODE + 1;
    localparam int POS_SET   = POS_PART + 1;
    localparam int CFG_AW    = POS_SET + SET_W;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_RSVD  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic [SET_W-1:0] set;
        logic             code_part;
        logic             is_mode;
        logic [IDX_W-1:0] idx;
        logic             upper;
    } cfg_sel_t;

    typedef struct packed {
        logic      grant;
        logic      trap;
        acc_kind_e kind;
    } verdict_t;

    function automatic cfg_sel_t split_cfg(input logic [CFG_AW-1:0] a);
        cfg_sel_t s;
        s.set       = a[POS_SET +: SET_W];
        s.code_part = a[POS_PART];
        s.is_mode   = a[POS_MODE];
        s.idx       = a[POS_IDX +: IDX_W];
        s.upper     = a[POS_UPPER];
        return s;
    endfunction

endpackage

// File: rtl/mpu_bound_file.sv
module mpu_bound_file #(
    parameter int AW    = 32,
    parameter int NSETS = 4,
    parameter int NWIN  = 4,
    parameter int PERM  = 2,
    parameter int IDXW  = 2,
    parameter int SETW  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SETW-1:0]      wr_set,
    input  logic                 wr_mode,
    input  logic [IDXW-1:0]      wr_idx,
    input  logic                 wr_upper,
    input  logic [AW-1:0]        wr_data,
    input  logic [SETW-1:0]      rd_set,
    input  logic [AW-1:0]        addr,
    output logic [NWIN-1:0]      hit,
    output logic [NWIN*PERM-1:0] mode
);
    localparam int MW = NWIN * PERM;

    logic [AW-1:0] lo_q   [NSETS][NWIN];
    logic [AW-1:0] hi_q   [NSETS][NWIN];
    logic [MW-1:0] mode_q [NSETS];

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        logic set_hit;
        assign set_hit = wr_en && (wr_set == SETW'(s));

        always_ff @(posedge clk) begin
            if (rst)
                mode_q[s] <= '0;
            else if (set_hit && wr_mode)
                mode_q[s] <= wr_data[MW-1:0];
        end

        for (genvar w = 0; w < NWIN; w++) begin : g_win
            logic win_wr;
            assign win_wr = set_hit && !wr_mode && (wr_idx == IDXW'(w));

            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_q[s][w] <= '0;
                    hi_q[s][w] <= '0;
                end else if (win_wr) begin
                    if (wr_upper)
                        hi_q[s][w] <= wr_data;
                    else
                        lo_q[s][w] <= wr_data;
                end
            end
        end
    end

    // Half-open containment test on the active set
    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        assign hit[w] = (addr >= lo_q[rd_set][w]) && (addr < hi_q[rd_set][w]);
    end

    assign mode = mode_q[rd_set];

endmodule

// File: rtl/mpu_decide.sv
module mpu_decide
    import mpu_pkg::*;
#(
    parameter int DWIN = 4,
    parameter int CWIN = 2
) (
    input  acc_kind_e             kind,
    input  logic [DWIN-1:0]       d_hit,
    input  logic [DWIN*2-1:0]     d_mode,
    input  logic [CWIN-1:0]       c_hit,
    input  logic [CWIN-1:0]       c_mode,
    output logic                  allow
);
    logic rd_ok, wr_ok, ex_ok;

    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        ex_ok = 1'b0;
        for (int i = 0; i < DWIN; i++) begin
            rd_ok = rd_ok | (d_hit[i] & d_mode[2*i]);
            wr_ok = wr_ok | (d_hit[i] & d_mode[2*i+1]);
        end
        for (int j = 0; j < CWIN; j++)
            ex_ok = ex_ok | (c_hit[j] & c_mode[j]);
    end

    always_comb begin
        unique case (kind)
            KIND_READ:  allow = rd_ok;
            KIND_WRITE: allow = wr_ok;
            KIND_FETCH: allow = ex_ok;
            default:    allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/range_mpu.sv
module range_mpu
    import mpu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic [SET_W-1:0]  set_sel,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [AW-1:0]     acc_addr,
    output logic              acc_grant,
    output logic              acc_trap,
    output logic [1:0]        trap_kind
);
    cfg_sel_t  csel;
    acc_kind_e kind;
    logic      allow;
    verdict_t  vd_d, vd_q;

    logic [DATA_WINS-1:0]            d_hit;
    logic [DATA_WINS*DATA_PERMS-1:0] d_mode;
    logic [CODE_WINS-1:0]            c_hit;
    logic [CODE_WINS*CODE_PERMS-1:0] c_mode;

    assign csel = split_cfg(cfg_addr);
    assign kind = acc_kind_e'(acc_kind);

    mpu_bound_file #(
        .AW(AW), .NSETS(NUM_SETS), .NWIN(DATA_WINS), .PERM(DATA_PERMS),
        .IDXW(IDX_W), .SETW(SET_W)
    ) u_data (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we && !csel.code_part),
        .wr_set(csel.set), .wr_mode(csel.is_mode), .wr_idx(csel.idx),
        .wr_upper(csel.upper), .wr_data(cfg_wdata),
        .rd_set(set_sel), .addr(acc_addr),
        .hit(d_hit), .mode(d_mode)
    );

    mpu_bound_file #(
        .AW(AW), .NSETS(NUM_SETS), .NWIN(CODE_WINS), .PERM(CODE_PERMS),
        .IDXW(IDX_W), .SETW(SET_W)
    ) u_code (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we && csel.code_part),
        .wr_set(csel.set), .wr_mode(csel.is_mode), .wr_idx(csel.idx),
        .wr_upper(csel.upper), .wr_data(cfg_wdata),
        .rd_set(set_sel), .addr(acc_addr),
        .hit(c_hit), .mode(c_mode)
    );

    mpu_decide #(.DWIN(DATA_WINS), .CWIN(CODE_WINS)) u_decide (
        .kind(kind), .d_hit(d_hit), .d_mode(d_mode),
        .c_hit(c_hit), .c_mode(c_mode), .allow(allow)
    );

    always_comb begin
        vd_d.grant = acc_valid && allow;
        vd_d.trap  = acc_valid && !allow;
        vd_d.kind  = vd_d.trap ? kind : KIND_READ;
    end

    always_ff @(posedge clk) begin
        if (rst)
            vd_q <= '{grant: 1'b0, trap: 1'b0, kind: KIND_READ};
        else
            vd_q <= vd_d;
    end

    assign acc_grant = vd_q.grant;
    assign acc_trap  = vd_q.trap;
    assign trap_kind = vd_q.kind;

endmodule

// File: rtl/range_mpu_checker.sv
module range_mpu_checker (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic [1:0] acc_kind,
    input logic       acc_grant,
    input logic       acc_trap,
    input logic [1:0] trap_kind
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R9
    grant_trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc_grant, acc_trap}));

    // R9
    verdict_follows_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (acc_grant || acc_trap));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!acc_grant && !acc_trap));

    // R10
    trap_kind_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        acc_trap |-> (trap_kind == $past(acc_kind)));

    // R10
    trap_kind_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_trap |-> (trap_kind == 2'b00));

    // R12
    rsvd_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_kind == 2'b11) |=> acc_trap);

endmodule

bind range_mpu range_mpu_checker u_range_mpu_checker (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_grant(acc_grant), .acc_trap(acc_trap), .trap_kind(trap_kind)
);

// File: tb/range_mpu_bench.sv
`timescale 1ns/1ps
module range_mpu_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [6:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [1:0]  set_sel;
    logic        acc_valid;
    logic [1:0]  acc_kind;
    logic [31:0] acc_addr;
    logic        acc_grant, acc_trap;
    logic [1:0]  trap_kind;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference state
    logic [31:0] m_dlo [4][4];
    logic [31:0] m_dhi [4][4];
    logic [7:0]  m_dm  [4];
    logic [31:0] m_clo [4][2];
    logic [31:0] m_chi [4][2];
    logic [1:0]  m_cm  [4];

    always #2 clk = ~clk;

    range_mpu u_range_mpu (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .set_sel(set_sel), .acc_valid(acc_valid),
        .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_grant(acc_grant),
        .acc_trap(acc_trap), .trap_kind(trap_kind)
    );

    function automatic logic ref_allow(input int s, input logic [31:0] a, input logic [1:0] k);
        logic ok = 1'b0;
        if (k == 2'b00 || k == 2'b01) begin
            for (int i = 0; i < 4; i++)
                if (a >= m_dlo[s][i] && a < m_dhi[s][i] && m_dm[s][2*i + int'(k)])
                    ok = 1'b1;
        end else if (k == 2'b10) begin
            for (int i = 0; i < 2; i++)
                if (a >= m_clo[s][i] && a < m_chi[s][i] && m_cm[s][i])
                    ok = 1'b1;
        end
        return ok;
    endfunction

    task automatic cfg_write(input logic [1:0] s, input logic code, input logic md,
                             input logic [1:0] idx, input logic up, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {s, code, md, idx, up};
        cfg_wdata = d;
        acc_valid = 1'b0;
        @(posedge clk);
        if (!code) begin
            if (md) m_dm[s] = d[7:0];
            else if (up) m_dhi[s][idx] = d;
            else m_dlo[s][idx] = d;
        end else begin
            if (md) m_cm[s] = d[1:0];
            else if (idx < 2) begin
                if (up) m_chi[s][idx[0]] = d;
                else m_clo[s][idx[0]] = d;
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic win(input logic [1:0] s, input logic code, input logic [1:0] idx,
                       input logic [31:0] lo, input logic [31:0] hi);
        cfg_write(s, code, 1'b0, idx, 1'b0, lo);
        cfg_write(s, code, 1'b0, idx, 1'b1, hi);
    endtask

    task automatic access(input logic v, input logic [1:0] s, input logic [31:0] a,
                          input logic [1:0] k, input string req);
        logic eg, et;
        logic [1:0] ek;
        @(negedge clk);
        cfg_we    = 1'b0;
        acc_valid = v;
        set_sel   = s;
        acc_addr  = a;
        acc_kind  = k;
        eg = v && ref_allow(int'(s), a, k);
        et = v && !eg;
        ek = et ? k : 2'b00;
        @(posedge clk);
        #1;
        n_chk++;
        if (acc_grant !== eg || acc_trap !== et || trap_kind !== ek) begin
            n_bad++;
            $display("FAIL %s: set=%0d addr=%h kind=%0d valid=%0d got g/t/k=%b/%b/%0d exp %b/%b/%0d",
                     req, s, a, k, v, acc_grant, acc_trap, trap_kind, eg, et, ek);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int s = 0; s < 4; s++) begin
            m_dm[s] = '0; m_cm[s] = '0;
            for (int i = 0; i < 4; i++) begin m_dlo[s][i] = '0; m_dhi[s][i] = '0; end
            for (int i = 0; i < 2; i++) begin m_clo[s][i] = '0; m_chi[s][i] = '0; end
        end
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        set_sel = '0; acc_valid = 1'b0; acc_kind = '0; acc_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: everything denied after reset
        access(1, 2'd0, 32'h0, 2'b00, "R1");
        access(1, 2'd2, 32'h0, 2'b01, "R1");
        access(1, 2'd3, 32'h0, 2'b10, "R1");
        // R9: idle cycle gives no verdict
        access(0, 2'd0, 32'h0, 2'b00, "R9");

        // Set 0: data window 0 [0x100,0x200) read only
        win(2'd0, 1'b0, 2'd0, 32'h100, 32'h200);
        cfg_write(2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0000_0001);
        access(1, 2'd0, 32'h100, 2'b00, "R2");
        access(1, 2'd0, 32'h1FF, 2'b00, "R2");
        access(1, 2'd0, 32'h200, 2'b00, "R2");
        access(1, 2'd0, 32'h0FF, 2'b00, "R2");
        access(1, 2'd0, 32'h150, 2'b00, "R3");
        access(1, 2'd0, 32'h150, 2'b01, "R4");
        access(1, 2'd0, 32'h150, 2'b10, "R6");

        // Data window 1 [0x1000,0x2000) read+write
        win(2'd0, 1'b0, 2'd1, 32'h1000, 32'h2000);
        cfg_write(2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0000_000D);
        access(1, 2'd0, 32'h1800, 2'b01, "R4");
        access(1, 2'd0, 32'h1800, 2'b00, "R3");

        // Code window 0 [0x4000,0x5000) execute
        win(2'd0, 1'b1, 2'd0, 32'h4000, 32'h5000);
        cfg_write(2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 32'h0000_0003);
        access(1, 2'd0, 32'h4800, 2'b10, "R5");
        access(1, 2'd0, 32'h4800, 2'b00, "R6");
        access(1, 2'd0, 32'h1800, 2'b10, "R6");

        // R7: other set does not see set 0 windows
        access(1, 2'd1, 32'h150, 2'b00, "R7");
        access(1, 2'd1, 32'h4800, 2'b10, "R7");

        // R8: overlapping window without rights does not veto
        win(2'd0, 1'b0, 2'd2, 32'h0, 32'h180);
        access(1, 2'd0, 32'h150, 2'b00, "R8");
        access(1, 2'd0, 32'h050, 2'b00, "R8");

        // R12: reserved kind denied inside granting windows
        access(1, 2'd0, 32'h150, 2'b11, "R12");
        access(1, 2'd0, 32'h4800, 2'b11, "R12");

        // R11: code index 2 write ignored; empty window
        win(2'd0, 1'b1, 2'd2, 32'h0, 32'hFFFF_FFFF);
        access(1, 2'd0, 32'h9000, 2'b10, "R11");
        win(2'd0, 1'b0, 2'd3, 32'h300, 32'h300);
        access(1, 2'd0, 32'h300, 2'b01, "R2");
        // R10 trap kind on a denied write
        access(1, 2'd2, 32'h300, 2'b01, "R10");

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int pick = int'($urandom_range(0, 9));
            if (pick < 3) begin
                logic [1:0] s  = 2'($urandom_range(0, 3));
                logic       cp = 1'($urandom_range(0, 1));
                logic       md = ($urandom_range(0, 4) == 0);
                logic [1:0] ix = 2'($urandom_range(0, 3));
                logic       up = 1'($urandom_range(0, 1));
                logic [31:0] d = md ? 32'($urandom) : 32'($urandom_range(0, 1023));
                cfg_write(s, cp, md, ix, up, d);
            end else begin
                access(1'($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
                       32'($urandom_range(0, 1100)), 2'($urandom_range(0, 3)), "R3/R4/R5 random");
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule